// File: doc/BRIEF.md
# Serial Configuration Bitstream Loader

This block takes a configuration stream one bit per rising edge of the configuration clock. It writes the device's own program bits into configuration memory through a one-bit write port, and it passes the bits meant for devices further down a daisy chain to its serial output. After reset ends it reads the mode pins once. In a serial mode it first clears configuration memory. It then searches for a fixed preamble, reads a length count, and counts clock edges until that count is met. At that point it raises `done`, and on the next edge it releases user I/O.

Every device in a chain receives the same header, because header bits are forwarded as they arrive. Each device writes its own program and drops the 4-bit postamble that follows it. Bits after that are forwarded downstream. The length count covers every program in the chain and every postamble, plus one final bit for each slave device. With two devices the count is therefore 2·(program+4)+1. A two-bit timing select moves the assertion of `done` one edge earlier or one edge later than the nominal edge.

Top module: `cfg_serial_loader`

## Requirements
- R1: The mode pins are sampled once, on the first clock edge after reset is released. Code 3'b111 (slave serial) and code 3'b000 (master serial) start loading. Any other code, including 3'b101 (peripheral), holds the block idle until reset: no write strobe, `done` low, `sdout` high. A change on the mode pins after that first edge has no effect.
- R2: Right after the mode edge in a serial mode, the block asserts `mem_we` with `mem_wdata`=0 on exactly MEM_BITS consecutive edges. Serial input arriving during this clear phase is ignored, and a preamble sent then is not detected.
- R3: After the clear phase, the block looks for the PRE_W-bit pattern PATTERN (default 16'h0F2D) in a sliding window, first bit received = MSB. Stray bits that come before the pattern are ignored.
- R4: The LEN_W bits after the preamble, MSB first, form the length count L. Preamble and length together make a 40-bit header.
- R5: Post-header bits 1..PROG_BITS each produce `mem_we`=1, with `mem_wdata` equal to that bit, on the edge that samples it.
- R6: The POST_BITS (4) bits after the program produce no write, and `sdout` stays 1 while they arrive.
- R7: `sdout` carries the bit sampled on the same edge for stray and header bits and for every bit after the postamble. It is 1 while the device's own program and postamble arrive.
- R8: Counting the first post-header edge as 1, `done` rises on edge L when `done_adj`=2'b00 (or 2'b11), on edge L-1 when it is 2'b01, and on edge L+1 when it is 2'b10. It then stays high until reset.
- R9: `io_en` rises on the edge after `done` rises.
- R10: `rst_n` low aborts loading at any point. While it is low, `done`, `io_en` and `mem_we` are 0 and `sdout` is 1. After release the full sequence restarts from the mode edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset and abort |
| mode_pins | input | 3 | Configuration mode code, sampled once |
| done_adj | input | 2 | Done timing select: 00 nominal, 01 early, 10 late |
| sdin | input | 1 | Serial configuration data in |
| sdout | output | 1 | Serial data out to the next device in the chain |
| done | output | 1 | Configuration complete |
| io_en | output | 1 | User I/O enable (internal reset released) |
| mem_we | output | 1 | Configuration memory write strobe |
| mem_wdata | output | 1 | Configuration memory write data |

## Verification
If the clear counter or the state register goes wrong, the number of zero-data strobes changes. It also moves every later event by whole edges, and the per-edge comparison reports that on the first misplaced cycle. A corrupted length register or bit counter shows up as `done` or `io_en` rising one or more edges away from L-1, L or L+1. A wrong region boundary shows up as a program bit that is not written, or as a postamble bit that leaks to `sdout`, on the cycle where that boundary falls.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef enum logic [2:0] {
        ST_INIT  = 3'd0,
        ST_CLEAR = 3'd1,
        ST_HUNT  = 3'd2,
        ST_LEN   = 3'd3,
        ST_LOAD  = 3'd4,
        ST_HOLD  = 3'd5
    } ld_state_e;

    localparam logic [2:0] MODE_SLAVE_SER  = 3'b111;
    localparam logic [2:0] MODE_MASTER_SER = 3'b000;
    localparam logic [2:0] MODE_PERIPH     = 3'b101;

    typedef enum logic [1:0] {
        ADJ_NOMINAL = 2'b00,
        ADJ_EARLY   = 2'b01,
        ADJ_LATE    = 2'b10,
        ADJ_SPARE   = 2'b11
    } done_adj_e;

endpackage

// File: rtl/cfg_preamble_det.sv
module cfg_preamble_det #(
    parameter int                PRE_W   = 16,
    parameter logic [PRE_W-1:0]  PATTERN = 16'h0F2D
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic shift,
    input  logic din,
    output logic hit
);
    // window keeps the PRE_W-1 most recent bits; the current bit completes it
    logic [PRE_W-2:0] win_q, win_d;
    logic [PRE_W-1:0] view;

    always_comb begin
        view  = {win_q, din};
        win_d = win_q;
        if (restart)
            win_d = '1;
        else if (shift)
            win_d = view[PRE_W-2:0];
        hit = shift && !restart && (view == PATTERN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            win_q <= '1;
        else
            win_q <= win_d;
    end

endmodule

// File: rtl/cfg_len_count.sv
module cfg_len_count import cfg_pkg::*; #(
    parameter int LEN_W = 24,
    localparam int CW   = LEN_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          len_shift,
    input  logic          inc,
    input  logic          din,
    input  logic [1:0]    adj,
    output logic [CW-1:0] cnt,
    output logic          target_hit
);
    logic [LEN_W-1:0] len_q, len_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic [CW-1:0]    tgt;
    logic [CW-1:0]    len_x;

    always_comb begin
        len_x = {1'b0, len_q};
        case (done_adj_e'(adj))
            ADJ_EARLY: tgt = len_x - 1'b1;
            ADJ_LATE:  tgt = len_x + 1'b1;
            default:   tgt = len_x;
        endcase

        len_d = len_shift ? {len_q[LEN_W-2:0], din} : len_q;

        if (clr)
            cnt_d = '0;
        else if (len_shift || inc)
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;

        target_hit = inc && ((cnt_q + 1'b1) == tgt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            cnt_q <= '0;
        end else begin
            len_q <= len_d;
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    // R4: the length register only moves while the length field is shifting
    a_r4_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !len_shift |=> (len_q == $past(len_q)));

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader import cfg_pkg::*; #(
    parameter int               PRE_W     = 16,
    parameter int               LEN_W     = 24,
    parameter int               PROG_BITS = 64,
    parameter int               POST_BITS = 4,
    parameter int               MEM_BITS  = 64,
    parameter logic [PRE_W-1:0] PATTERN   = 16'h0F2D
) (
    input  logic       cclk,
    input  logic       rst_n,
    input  logic [2:0] mode_pins,
    input  logic [1:0] done_adj,
    input  logic       sdin,
    output logic       sdout,
    output logic       done,
    output logic       io_en,
    output logic       mem_we,
    output logic       mem_wdata
);
    localparam int CW  = LEN_W + 1;
    localparam int CLW = $clog2(MEM_BITS) + 1;
    localparam logic [CW-1:0]  PROG_END = CW'(PROG_BITS);
    localparam logic [CW-1:0]  POST_END = CW'(PROG_BITS + POST_BITS);
    localparam logic [CW-1:0]  LEN_LAST = CW'(LEN_W - 1);
    localparam logic [CLW-1:0] CLR_LAST = CLW'(MEM_BITS - 1);

    typedef struct packed {
        ld_state_e      st;
        logic [CLW-1:0] clr;
        logic           dout;
        logic           done;
        logic           io_en;
        logic           we;
        logic           wd;
    } core_t;

    core_t q, d;

    logic          pd_restart, pd_shift, pd_hit;
    logic          lc_clr, lc_len, lc_inc, lc_tgt;
    logic [CW-1:0] lc_cnt, k;

    cfg_preamble_det #(.PRE_W(PRE_W), .PATTERN(PATTERN)) u_pre (
        .clk     (cclk),
        .rst_n   (rst_n),
        .restart (pd_restart),
        .shift   (pd_shift),
        .din     (sdin),
        .hit     (pd_hit)
    );

    cfg_len_count #(.LEN_W(LEN_W)) u_len (
        .clk        (cclk),
        .rst_n      (rst_n),
        .clr        (lc_clr),
        .len_shift  (lc_len),
        .inc        (lc_inc),
        .din        (sdin),
        .adj        (done_adj),
        .cnt        (lc_cnt),
        .target_hit (lc_tgt)
    );

    always_comb begin
        d          = q;
        d.we       = 1'b0;
        d.wd       = 1'b0;
        d.dout     = 1'b1;
        pd_restart = 1'b0;
        pd_shift   = 1'b0;
        lc_clr     = 1'b0;
        lc_len     = 1'b0;
        lc_inc     = 1'b0;
        k          = lc_cnt + 1'b1;

        case (q.st)
            ST_INIT: begin
                pd_restart = 1'b1;
                lc_clr     = 1'b1;
                d.clr      = '0;
                if (mode_pins == MODE_SLAVE_SER || mode_pins == MODE_MASTER_SER)
                    d.st = ST_CLEAR;
                else
                    d.st = ST_HOLD;
            end
            ST_CLEAR: begin
                pd_restart = 1'b1;
                d.we       = 1'b1;
                if (q.clr == CLR_LAST)
                    d.st = ST_HUNT;
                else
                    d.clr = q.clr + 1'b1;
            end
            ST_HUNT: begin
                pd_shift = 1'b1;
                d.dout   = sdin;
                if (pd_hit) begin
                    lc_clr = 1'b1;
                    d.st   = ST_LEN;
                end
            end
            ST_LEN: begin
                lc_len = 1'b1;
                d.dout = sdin;
                if (lc_cnt == LEN_LAST) begin
                    lc_clr = 1'b1;
                    d.st   = ST_LOAD;
                end
            end
            ST_LOAD: begin
                lc_inc  = !q.done;
                d.done  = q.done | lc_tgt;
                d.io_en = q.done;
                if (q.done || k > POST_END) begin
                    d.dout = sdin;
                end else if (k <= PROG_END) begin
                    d.we = 1'b1;
                    d.wd = sdin;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge cclk or negedge rst_n) begin
        if (!rst_n)
            q <= '{st: ST_INIT, clr: '0, dout: 1'b1, done: 1'b0,
                   io_en: 1'b0, we: 1'b0, wd: 1'b0};
        else
            q <= d;
    end

    assign sdout     = q.dout;
    assign done      = q.done;
    assign io_en     = q.io_en;
    assign mem_we    = q.we;
    assign mem_wdata = q.wd;

    // R8: done is sticky until reset
    a_r8_done_sticky: assert property (@(posedge cclk) disable iff (!rst_n)
        q.done |=> q.done);

    // R9: io_en only follows an earlier done
    a_r9_io_after_done: assert property (@(posedge cclk) disable iff (!rst_n)
        q.io_en |-> $past(q.done));

    // R2, R5: strobes only come from the clear or load phases
    a_r5_we_source: assert property (@(posedge cclk) disable iff (!rst_n)
        q.we |-> ($past(q.st) == ST_CLEAR || $past(q.st) == ST_LOAD));

    // R2: nonzero write data only from the load phase
    a_r2_clear_zero: assert property (@(posedge cclk) disable iff (!rst_n)
        q.wd |-> ($past(q.st) == ST_LOAD));

    // R1: an idle mode never writes nor completes
    a_r1_hold_quiet: assert property (@(posedge cclk) disable iff (!rst_n)
        (q.st == ST_HOLD) |-> (!q.we && !q.done && q.dout));

    // R8: the length compare fires at most once
    a_r8_single_hit: assert property (@(posedge cclk) disable iff (!rst_n)
        lc_tgt |=> !lc_tgt);

endmodule

// File: tb/cfg_serial_loader_test.sv
module cfg_serial_loader_test;
    localparam int PRE_W = 16;
    localparam int LEN_W = 24;
    localparam int PROG  = 24;
    localparam int POST  = 4;
    localparam int MEMB  = 16;
    localparam logic [15:0] PAT = 16'h0F2D;
    localparam int STRAY = 6;
    localparam int HS    = STRAY + PRE_W + LEN_W;
    localparam int LCNT  = 2 * (PROG + POST) + 1;   // two devices, one slave extra bit
    localparam int NBITS = HS + 2 * (PROG + POST) + 1 + 6;

    logic       cclk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_pins = 3'b111;
    logic [1:0] done_adj = 2'b00;
    logic       sdin = 1'b1;
    logic       sdout, done, io_en, mem_we, mem_wdata;

    int n_chk = 0;
    int n_bad = 0;
    logic s [0:NBITS-1];

    always #5 cclk = ~cclk;

    cfg_serial_loader #(
        .PRE_W(PRE_W), .LEN_W(LEN_W), .PROG_BITS(PROG), .POST_BITS(POST),
        .MEM_BITS(MEMB), .PATTERN(PAT)
    ) uut (
        .cclk(cclk), .rst_n(rst_n), .mode_pins(mode_pins), .done_adj(done_adj),
        .sdin(sdin), .sdout(sdout), .done(done), .io_en(io_en),
        .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at %0t: actual=%b expected=%b", tag, what, $time, act, exp);
        end
    endtask

    function automatic logic img_bit(input int dev, input int b);
        return ((b * 13 + dev * 5) % 7) > 3;
    endfunction

    task automatic build();
        logic [5:0]       stray = 6'b110110;
        logic [LEN_W-1:0] lv = LEN_W'(LCNT);
        int p = 0;
        for (int i = 0; i < STRAY; i++) begin s[p] = stray[5-i]; p++; end
        for (int i = 0; i < PRE_W; i++) begin s[p] = PAT[PRE_W-1-i]; p++; end
        for (int i = 0; i < LEN_W; i++) begin s[p] = lv[LEN_W-1-i]; p++; end
        for (int dv = 0; dv < 2; dv++) begin
            for (int i = 0; i < PROG; i++) begin s[p] = img_bit(dv, i); p++; end
            for (int i = 0; i < POST; i++) begin s[p] = (i != 0); p++; end
        end
        s[p] = 1'b1; p++;
        for (int i = 0; i < 6; i++) begin s[p] = 1'b1; p++; end
    endtask

    task automatic run(input logic [2:0] md, input logic [1:0] adj,
                       input bit flip, input int abort_k);
        bit serial;
        int tgt;
        rst_n = 1'b0; sdin = 1'b1; mode_pins = md; done_adj = adj;
        repeat (3) @(negedge cclk);
        chk("R10", "done in reset", done, 1'b0);
        chk("R10", "io_en in reset", io_en, 1'b0);
        chk("R10", "we in reset", mem_we, 1'b0);
        chk("R10", "sdout in reset", sdout, 1'b1);
        rst_n = 1'b1;
        serial = (md == 3'b111) || (md == 3'b000);
        tgt = (adj == 2'b01) ? LCNT - 1 : (adj == 2'b10) ? LCNT + 1 : LCNT;
        // mode edge then clear phase; preamble bits sent here must be ignored (R2)
        for (int e = 1; e <= MEMB + 1; e++) begin
            sdin = PAT[PRE_W-1-((e-1) % PRE_W)];
            @(negedge cclk);
            if (flip) mode_pins = 3'b101;
            if (e == 1 || !serial) begin
                chk("R1", "we on mode edge/idle", mem_we, 1'b0);
            end else begin
                chk("R2", "clear strobe", mem_we, 1'b1);
                chk("R2", "clear data", mem_wdata, 1'b0);
            end
            chk("R2", "sdout during clear", sdout, 1'b1);
        end
        for (int i = 0; i < NBITS; i++) begin
            int k;
            sdin = s[i];
            @(negedge cclk);
            k = (i >= HS) ? i - HS + 1 : 0;
            if (!serial) begin
                chk("R1", "idle we", mem_we, 1'b0);
                chk("R1", "idle sdout", sdout, 1'b1);
                chk("R1", "idle done", done, 1'b0);
            end else begin
                if (k == 0) begin
                    chk("R3", "no write before header end", mem_we, 1'b0);
                    chk("R7", "header forwarded", sdout, s[i]);
                end else if (k <= PROG) begin
                    chk("R5", "program strobe", mem_we, 1'b1);
                    chk("R5", "program data", mem_wdata, s[i]);
                    chk("R7", "own program masked", sdout, 1'b1);
                end else if (k <= PROG + POST) begin
                    chk("R6", "postamble no write", mem_we, 1'b0);
                    chk("R6", "postamble masked", sdout, 1'b1);
                end else begin
                    chk("R7", "downstream forwarded", sdout, s[i]);
                    chk("R7", "no write downstream", mem_we, 1'b0);
                end
                chk("R8", "done timing (R4 length)", done, (k != 0 && k >= tgt));
                chk("R9", "io_en timing", io_en, (k != 0 && k >= tgt + 1));
            end
            if (abort_k > 0 && k == abort_k) begin
                rst_n = 1'b0;
                #1;
                chk("R10", "abort done", done, 1'b0);
                chk("R10", "abort we", mem_we, 1'b0);
                chk("R10", "abort sdout", sdout, 1'b1);
                chk("R10", "abort io_en", io_en, 1'b0);
                @(negedge cclk);
                return;
            end
        end
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        build();
        run(3'b111, 2'b00, 1'b0, 0);
        run(3'b000, 2'b01, 1'b0, 0);
        run(3'b111, 2'b10, 1'b1, 0);   // R1: mode change after sampling ignored
        run(3'b101, 2'b00, 1'b0, 0);
        run(3'b111, 2'b00, 1'b0, PROG + 10);
        run(3'b111, 2'b11, 1'b0, 0);   // restart after abort, spare code = nominal
        finish_up();
    end

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL R8 watchdog: actual=running expected=finished");
        finish_up();
    end

endmodule